// File: doc/BRIEF.md
# Conditional Backward-Branch Evaluation Unit

This unit resolves one kind of instruction in a small register-based virtual machine core: a conditional branch that jumps backwards. For each branch it builds a 64-bit condition constant from a 32-bit immediate and a 4-bit condition field. It adds that constant into one of eight 64-bit integer registers and writes the sum back. It then tests a window of bits in the sum to decide whether the branch is taken.

The jump target does not come from an offset. The unit keeps, for every register, the instruction index of the last instruction that wrote it. A taken branch jumps to the instruction right after that writer. Other instructions in the core report their register writes through a write-notify port, which carries the written value and the writer's instruction index. The branch itself then becomes the last writer of the register it touched. Because every pass through the branch adds a constant with a forced bit inside the tested window, a loop that keeps taking the branch always falls through after a bounded number of passes.

Top module: `cbranch_unit`

## Requirements
- R1: The bit position b equals the condition field plus the parameter JUMP_OFFSET (default 8). The condition constant is the immediate sign-extended to 64 bits, with bit b forced to 1 and, when b > 0, bit b-1 forced to 0. Bit 0 is the least significant bit.
- R2: On a branch, the selected register becomes its old value plus the condition constant, taken modulo 2^64, and that sum appears on `res_value`.
- R3: The branch is taken (`res_taken` = 1) exactly when bits b to b+JUMP_BITS-1 of the sum are all zero. With the default JUMP_BITS = 8 and b = 10, bits 10 to 17 are tested.
- R4: A taken branch reports `res_target` = (last-writer index of the selected register) + 1, modulo 2^IDX_W. A branch that is not taken reports `br_idx` + 1.
- R5: A write notification sets the named register to `wn_data` and sets its last-writer entry to `wn_idx`.
- R6: After a branch, the branch's own `br_idx` is the last-writer entry of the selected register.
- R7: After reset, every register reads 0 and every last-writer entry is all ones (-1). `res_valid`, `res_taken`, `res_target` and `res_value` are 0.
- R8: `res_valid` is high for exactly the cycle after each cycle in which `br_valid` is high. While it is low, `res_taken`, `res_target` and `res_value` keep their last values.
- R9: If a branch and a write notification name the same register in the same cycle, the branch result and the branch index win. A write to a different register in that cycle still takes effect.
- R10: Repeating a taken branch on the same register with the same immediate and condition field eventually gives a branch that is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A branch is presented this cycle |
| br_reg | input | 3 | Selected register |
| br_imm | input | 32 | Branch immediate |
| br_cond | input | 4 | Condition field |
| br_idx | input | 16 | Instruction index of the branch |
| wn_valid | input | 1 | A register write is reported this cycle |
| wn_reg | input | 3 | Register that was written |
| wn_data | input | 64 | Value written |
| wn_idx | input | 16 | Instruction index of the writer |
| res_valid | output | 1 | Branch result pulse |
| res_taken | output | 1 | Branch taken |
| res_target | output | 16 | Next instruction index |
| res_value | output | 64 | New value of the selected register |

## Verification
The assertions assume that JUMP_OFFSET + 15 + JUMP_BITS stays within 64, so the tested window never runs past bit 63. They also assume that `br_valid` is held low during reset, so the first result pulse always has a real branch one cycle behind it. The stimulus drives `br_valid` low through reset and uses only the default parameters. Random operations mix branches and write notifications, including same-register collisions. Some writes are chosen as the negative of the upcoming condition constant, so that taken branches occur often.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int DEF_XLEN        = 64;
    localparam int DEF_IMM_W       = 32;
    localparam int DEF_COND_W      = 4;
    localparam int DEF_NUM_REGS    = 8;
    localparam int DEF_IDX_W       = 16;
    localparam int DEF_JUMP_OFFSET = 8;
    localparam int DEF_JUMP_BITS   = 8;
endpackage

// File: rtl/cbr_cimm_gen.sv
module cbr_cimm_gen #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32,
    parameter int POS_W = $clog2(XLEN)
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [POS_W-1:0] pos,
    output logic [XLEN-1:0]  cimm
);
    logic [XLEN-1:0] ext;
    assign ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (i < XLEN - 1) begin : g_mid
            // bit i is forced high at pos, forced low just below pos
            assign cimm[i] = (pos == POS_W'(i))     ? 1'b1 :
                             (pos == POS_W'(i + 1)) ? 1'b0 : ext[i];
        end else begin : g_top
            assign cimm[i] = (pos == POS_W'(i)) ? 1'b1 : ext[i];
        end
    end
endmodule

// File: rtl/cbr_window_test.sv
module cbr_window_test #(
    parameter int XLEN      = 64,
    parameter int JUMP_BITS = 8,
    parameter int POS_W     = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  value,
    input  logic [POS_W-1:0] pos,
    output logic             all_zero
);
    logic [XLEN-1:0] shifted;
    assign shifted  = value >> pos;
    assign all_zero = ~|shifted[JUMP_BITS-1:0];
endmodule

// File: rtl/cbranch_unit.sv
module cbranch_unit #(
    parameter int XLEN        = cbr_pkg::DEF_XLEN,
    parameter int IMM_W       = cbr_pkg::DEF_IMM_W,
    parameter int COND_W      = cbr_pkg::DEF_COND_W,
    parameter int NUM_REGS    = cbr_pkg::DEF_NUM_REGS,
    parameter int IDX_W       = cbr_pkg::DEF_IDX_W,
    parameter int JUMP_OFFSET = cbr_pkg::DEF_JUMP_OFFSET,
    parameter int JUMP_BITS   = cbr_pkg::DEF_JUMP_BITS,
    localparam int SEL_W      = $clog2(NUM_REGS),
    localparam int POS_W      = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [SEL_W-1:0]  br_reg,
    input  logic [IMM_W-1:0]  br_imm,
    input  logic [COND_W-1:0] br_cond,
    input  logic [IDX_W-1:0]  br_idx,
    input  logic              wn_valid,
    input  logic [SEL_W-1:0]  wn_reg,
    input  logic [XLEN-1:0]   wn_data,
    input  logic [IDX_W-1:0]  wn_idx,
    output logic              res_valid,
    output logic              res_taken,
    output logic [IDX_W-1:0]  res_target,
    output logic [XLEN-1:0]   res_value
);
    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0]  regs;
        logic [NUM_REGS-1:0][IDX_W-1:0] last_wr;
        logic                           valid;
        logic                           taken;
        logic [IDX_W-1:0]               target;
        logic [XLEN-1:0]                value;
    } state_t;

    state_t state_d, state_q;

    logic [POS_W-1:0] bit_pos;
    logic [XLEN-1:0]  cond_const;
    logic [XLEN-1:0]  sum;
    logic             win_zero;

    assign bit_pos = POS_W'(JUMP_OFFSET) + POS_W'(br_cond);

    cbr_cimm_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .POS_W(POS_W)) u_cimm (
        .imm  (br_imm),
        .pos  (bit_pos),
        .cimm (cond_const)
    );

    assign sum = state_q.regs[br_reg] + cond_const;

    cbr_window_test #(.XLEN(XLEN), .JUMP_BITS(JUMP_BITS), .POS_W(POS_W)) u_win (
        .value    (sum),
        .pos      (bit_pos),
        .all_zero (win_zero)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (wn_valid) begin
            state_d.regs[wn_reg]    = wn_data;
            state_d.last_wr[wn_reg] = wn_idx;
        end
        // branch applied last so it overrides a same-register write
        if (br_valid) begin
            state_d.regs[br_reg]    = sum;
            state_d.last_wr[br_reg] = br_idx;
            state_d.valid           = 1'b1;
            state_d.taken           = win_zero;
            state_d.value           = sum;
            state_d.target          = win_zero ? state_q.last_wr[br_reg] + IDX_W'(1)
                                               : br_idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.last_wr <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid  = state_q.valid;
    assign res_taken  = state_q.taken;
    assign res_target = state_q.target;
    assign res_value  = state_q.value;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int XLEN        = 64,
    parameter int COND_W      = 4,
    parameter int IDX_W       = 16,
    parameter int JUMP_OFFSET = 8,
    parameter int JUMP_BITS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic [COND_W-1:0] br_cond,
    input logic [IDX_W-1:0]  br_idx,
    input logic              res_valid,
    input logic              res_taken,
    input logic [IDX_W-1:0]  res_target,
    input logic [XLEN-1:0]   res_value
);
    localparam logic [XLEN-1:0] WIN_MASK = (XLEN'(1) << JUMP_BITS) - XLEN'(1);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !res_valid);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_value) && $stable(res_target) && $stable(res_taken)));

    assert_taken_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_taken ==
            (((res_value >> ($past(br_cond) + JUMP_OFFSET)) & WIN_MASK) == '0)));

    assert_fallthrough_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> (res_target == $past(br_idx) + IDX_W'(1)));
endmodule

bind cbranch_unit cbr_checker #(
    .XLEN(XLEN), .COND_W(COND_W), .IDX_W(IDX_W),
    .JUMP_OFFSET(JUMP_OFFSET), .JUMP_BITS(JUMP_BITS)
) u_cbr_checker (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
    .br_idx(br_idx), .res_valid(res_valid), .res_taken(res_taken),
    .res_target(res_target), .res_value(res_value)
);

// File: tb/tb_cbranch_unit.sv
module tb_cbranch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_reg = '0;
    logic [31:0] br_imm = '0;
    logic [3:0]  br_cond = '0;
    logic [15:0] br_idx = '0;
    logic        wn_valid = 1'b0;
    logic [2:0]  wn_reg = '0;
    logic [63:0] wn_data = '0;
    logic [15:0] wn_idx = '0;
    logic        res_valid, res_taken;
    logic [15:0] res_target;
    logic [63:0] res_value;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_regs [8];
    logic [15:0] m_lw   [8];
    logic        m_taken;
    logic [15:0] m_target;
    logic [63:0] m_value;

    always #10 clk = ~clk;

    cbranch_unit dut (.*);

    function automatic logic [63:0] cimm_f(input logic [31:0] imm, input logic [3:0] cond);
        int b = int'(cond) + 8;
        logic [63:0] v = {{32{imm[31]}}, imm};
        v[b] = 1'b1;
        if (b > 0) v[b-1] = 1'b0;
        return v;
    endfunction

    function automatic logic win_zero_f(input logic [63:0] v, input logic [3:0] cond);
        int b = int'(cond) + 8;
        return ((v >> b) & 64'hFF) == 64'd0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a negedge, result visible at the next negedge
    task automatic op(input logic bv, input logic [2:0] br, input logic [31:0] imm,
                      input logic [3:0] cond, input logic [15:0] bidx,
                      input logic wv, input logic [2:0] wr, input logic [63:0] wd,
                      input logic [15:0] widx, input string tag);
        logic [63:0] s;
        br_valid = bv; br_reg = br; br_imm = imm; br_cond = cond; br_idx = bidx;
        wn_valid = wv; wn_reg = wr; wn_data = wd; wn_idx = widx;
        s = m_regs[br] + cimm_f(imm, cond);
        if (bv) begin
            m_taken  = win_zero_f(s, cond);
            m_target = m_taken ? m_lw[br] + 16'd1 : bidx + 16'd1;
            m_value  = s;
        end
        if (wv) begin m_regs[wr] = wd; m_lw[wr] = widx; end
        if (bv) begin m_regs[br] = s; m_lw[br] = bidx; end
        @(negedge clk);
        br_valid = 1'b0; wn_valid = 1'b0;
        check({tag, " valid"}, 64'(res_valid), 64'(bv));
        check({tag, " taken"}, 64'(res_taken), 64'(m_taken));
        check({tag, " target"}, 64'(res_target), 64'(m_target));
        check({tag, " value"}, res_value, m_value);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] idx;
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 8; i++) begin m_regs[i] = '0; m_lw[i] = '1; end
        m_taken = 0; m_target = 0; m_value = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 valid", 64'(res_valid), 64'd0);
        check("R7 taken", 64'(res_taken), 64'd0);
        check("R7 target", 64'(res_target), 64'd0);
        check("R7 value", res_value, 64'd0);

        // R1 R2: register 0 is zero, cond 2 -> b=10, imm 0x3FF -> bit10=1 bit9=0
        op(1, 3'd0, 32'h0000_03FF, 4'd2, 16'd5, 0, 0, 0, 0, "R1 cimm");
        check("R1 exact", res_value, 64'h0000_0000_0000_05FF);
        // R1 sign extension, b=8
        op(1, 3'd1, 32'h8000_0000, 4'd0, 16'd6, 0, 0, 0, 0, "R1 sign");
        check("R1 sign exact", res_value, 64'hFFFF_FFFF_8000_0100);

        // R5 then R3/R4 taken: reg2 = -0x100, cond0 imm0 -> sum 0, taken, target 41
        op(0, 0, 0, 0, 0, 1, 3'd2, 64'hFFFF_FFFF_FFFF_FF00, 16'd40, "R5 write");
        op(1, 3'd2, 32'd0, 4'd0, 16'd50, 0, 0, 0, 0, "R3 taken");
        check("R4 taken target", 64'(res_target), 64'd41);
        // R6 + R10: the retry falls through; last writer is now 50
        op(1, 3'd2, 32'd0, 4'd0, 16'd51, 0, 0, 0, 0, "R10 fallthrough");
        check("R10 not taken", 64'(res_taken), 64'd0);
        // R6: drive reg2 back to a taken state via R5? use collision-free check:
        // add -0x200 value: reg2=0x100; imm -0x200 with b=8 -> cimm=0x...FF00 -> sum 0
        op(1, 3'd2, 32'hFFFF_FE00, 4'd0, 16'd60, 0, 0, 0, 0, "R6 lastwr");
        check("R6 target", 64'(res_target), 64'd52);

        // R8 hold: idle cycle keeps outputs
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 hold");

        // R9 same-register collision: branch wins
        op(1, 3'd3, 32'd0, 4'd0, 16'd70, 1, 3'd3, 64'hFFFF_FFFF_FFFF_FF00, 16'd69, "R9 same");
        // R9 different register: write still lands, observed by a later branch
        op(1, 3'd4, 32'd0, 4'd1, 16'd80, 1, 3'd5, 64'hFFFF_FFFF_FFFF_FE00, 16'd79, "R9 other");
        op(1, 3'd5, 32'd0, 4'd1, 16'd81, 0, 0, 0, 0, "R9 other taken");
        check("R9 other target", 64'(res_target), 64'd80);

        // random mix
        idx = 16'd100;
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  r  = 3'($urandom_range(0, 7));
            logic [31:0] im = $urandom;
            logic [3:0]  c  = 4'($urandom_range(0, 15));
            logic [2:0]  wr = 3'($urandom_range(0, 7));
            int kind = $urandom_range(0, 3);
            idx = idx + 16'd2;
            if (kind == 0) begin
                // prime register so the following branch is taken
                op(0, 0, 0, 0, 0, 1, r, 64'(0) - cimm_f(im, c), idx, "R5 rand write");
                op(1, r, im, c, idx + 16'd1, 0, 0, 0, 0, "R3 rand taken");
            end else begin
                op(1, r, im, c, idx + 16'd1, kind == 1, wr,
                   {$urandom, $urandom}, idx, "R2 rand");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule